// File: doc/BRIEF.md
# I2C Target Address Decoder and Register Pointer

This block sits behind a bit-level I2C receiver. That receiver reports START and STOP events, delivers every byte the controller sends, tells the block how the controller acknowledged each byte read back, and drives the ACK or NACK the block asks for. The block checks the first byte after START against several target addresses. These are a fixed hardware address, an all-call address that can be switched on, a set of programmable sub-addresses with one enable each, and a software-reset call address. It then decides whether to acknowledge.

After a write address is accepted, the next byte is a control byte. Its low five bits load the register pointer. Its top three bits hold the auto-increment field, which decides whether the pointer moves on after every data byte or stays on one register. The block issues one-cycle write strobes and read strobes to an external register file, with the register address on `regAddr`. The register file reads the auto-increment field back as the top three bits of its first mode register. A software reset fires only after the reset call address is written and followed by A5h, then 5Ah, then STOP.

Top module: `i2c_addr_decoder`

## Requirements
- R1: After reset, `ackValid`, `wrStrobe`, `rdStrobe`, `swReset` and `txActive` are 0. `aiField` is 0 and the register pointer is 0.
- R2: Every byte delivered on `rxValid` gets exactly one `ackValid` pulse one cycle later. `ackBit`=1 means ACK and 0 means NACK. An address byte (7-bit address in bits 7:1, bit 0 = 1 for read) whose address matches `hwAddr` is ACKed. A non-matching address is NACKed, and every later byte up to the next START is also NACKed, with no write strobe.
- R3: Sub-address i (bits 7i+6:7i of `subAddr`) is ACKed only while `subEn[i]`=1. The all-call address is ACKed only while `allCallEn`=1.
- R4: The reset call address (default 7'h03) is ACKed with bit 0 = 0 and NACKed with bit 0 = 1.
- R5: The first byte after an accepted write address is a control byte. Bits 4:0 load the pointer and bits 7:5 appear on `aiField`, and the byte is ACKed. If bits 4:0 are at or above `NUM_REGS`, the byte is NACKed, the pointer and field stay unchanged, and the rest of the transfer is ignored.
- R6: Each later write byte is ACKed and produces a one-cycle `wrStrobe`, with `regAddr` equal to the pointer and `wrData` equal to the byte.
- R7: With `aiField` nonzero, the pointer advances by one after each data byte and wraps from `NUM_REGS`-1 to 0. With `aiField` = 000 it stays fixed.
- R8: An accepted read address raises `txActive` and gives a `rdStrobe` at the pointer. Each controller ACK of a read byte advances the pointer per R7 and gives a `rdStrobe` at the new pointer.
- R9: A controller NACK on a read byte still advances the pointer. It ends the read: `txActive` drops, no `rdStrobe` follows, and bytes are NACKed until the next START.
- R10: Reset call write, A5h, 5Ah, then STOP gives a one-cycle `swReset` and clears the pointer and `aiField`. A wrong byte at either step, or any extra byte, is NACKed and cancels the reset. A STOP before the sequence is complete gives no reset.
- R11: START in any state begins a new address phase without a reset pulse. After STOP, bytes are NACKed until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busStart | input | 1 | START or repeated START seen |
| busStop | input | 1 | STOP seen |
| rxValid | input | 1 | Byte from controller available |
| rxByte | input | 8 | Received byte |
| txDone | input | 1 | Read byte sent, controller ack bit valid |
| txMasterAck | input | 1 | 1 = controller ACKed the read byte |
| hwAddr | input | 7 | Hardware target address |
| allCallAddr | input | 7 | All-call address |
| allCallEn | input | 1 | All-call enable |
| subAddr | input | 7*NUM_SUB | Sub-addresses, entry i at bits 7i+6:7i |
| subEn | input | NUM_SUB | Sub-address enables |
| ackValid | output | 1 | Ack decision valid |
| ackBit | output | 1 | 1 = ACK, 0 = NACK |
| txActive | output | 1 | Read transfer in progress, drive data |
| wrStrobe | output | 1 | Register write strobe |
| rdStrobe | output | 1 | Register read strobe |
| regAddr | output | PTR_W | Register address for the strobe |
| wrData | output | 8 | Write data |
| aiField | output | 3 | Current auto-increment field |
| swReset | output | 1 | Software reset pulse |

## Verification
A wrong sequence state shows at the ports on the very next byte. The ACK bit flips, or a write strobe appears or goes missing, one cycle after `rxValid`. A corrupted pointer or auto-increment field stays hidden until the next strobe, so every test reads `regAddr` on each write and read strobe, including across separate transfers and after a software reset. A reset sequence tracker that drifts shows only at STOP, as a missing or extra `swReset`, so each broken variant of the sequence ends in a STOP.

// File: rtl/aptr_pkg.sv
package aptr_pkg;
  localparam int CTRL_AI_LSB = 5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_WDATA,
    ST_RDATA,
    ST_RST1,
    ST_RST2,
    ST_RSTOK,
    ST_SKIP
  } state_t;

  typedef struct packed {
    logic loadCtrl;
    logic stepPtr;
    logic issueWr;
    logic issueRd;
    logic clearAll;
  } strobe_t;
endpackage

// File: rtl/aptr_match.sv
module aptr_match #(
  parameter int NUM_SUB = 3,
  parameter logic [6:0] RESET_ADDR = 7'h03
) (
  input  logic [6:0]           addr,
  input  logic [6:0]           hwAddr,
  input  logic [6:0]           allCallAddr,
  input  logic                 allCallEn,
  input  logic [NUM_SUB*7-1:0] subAddr,
  input  logic [NUM_SUB-1:0]   subEn,
  output logic                 hit,
  output logic                 resetHit
);
  logic [NUM_SUB-1:0] subHit;

  for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
    assign subHit[i] = subEn[i] && (addr == subAddr[i*7 +: 7]);
  end

  assign hit = (addr == hwAddr) || (allCallEn && (addr == allCallAddr)) || (|subHit);
  assign resetHit = (addr == RESET_ADDR);
endmodule

// File: rtl/aptr_control.sv
module aptr_control #(
  parameter int NUM_REGS = 28,
  parameter logic [6:0] RESET_ADDR = 7'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              txDone,
  input  logic              txMasterAck,
  input  logic              hit,
  input  logic              resetHit,
  output aptr_pkg::strobe_t ctl,
  output logic              ackValid,
  output logic              ackBit,
  output logic              txActive,
  output logic              swReset
);
  import aptr_pkg::*;

  state_t stateQ, stateD;
  logic   ackVD, ackBD, rstD;
  logic   rw, ctrlInRange;

  assign rw = rxByte[0];
  assign ctrlInRange = (32'(rxByte[4:0]) < NUM_REGS);

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    ackVD  = 1'b0;
    ackBD  = 1'b0;
    rstD   = 1'b0;
    if (busStart) begin
      stateD = ST_ADDR;
    end else if (busStop) begin
      if (stateQ == ST_RSTOK) begin
        rstD         = 1'b1;
        ctl.clearAll = 1'b1;
      end
      stateD = ST_IDLE;
    end else if (rxValid) begin
      ackVD = 1'b1;
      case (stateQ)
        ST_ADDR: begin
          if (resetHit) begin
            if (!rw) begin
              ackBD  = 1'b1;
              stateD = ST_RST1;
            end else begin
              stateD = ST_SKIP;
            end
          end else if (hit) begin
            ackBD = 1'b1;
            if (rw) begin
              stateD      = ST_RDATA;
              ctl.issueRd = 1'b1;
            end else begin
              stateD = ST_CTRL;
            end
          end else begin
            stateD = ST_SKIP;
          end
        end
        ST_CTRL: begin
          if (ctrlInRange) begin
            ackBD        = 1'b1;
            ctl.loadCtrl = 1'b1;
            stateD       = ST_WDATA;
          end else begin
            stateD = ST_SKIP;
          end
        end
        ST_WDATA: begin
          ackBD       = 1'b1;
          ctl.issueWr = 1'b1;
          ctl.stepPtr = 1'b1;
        end
        ST_RST1: begin
          if (rxByte == 8'hA5) begin
            ackBD  = 1'b1;
            stateD = ST_RST2;
          end else begin
            stateD = ST_SKIP;
          end
        end
        ST_RST2: begin
          if (rxByte == 8'h5A) begin
            ackBD  = 1'b1;
            stateD = ST_RSTOK;
          end else begin
            stateD = ST_SKIP;
          end
        end
        ST_IDLE: stateD = ST_IDLE;
        default: stateD = ST_SKIP;
      endcase
    end else if (txDone && stateQ == ST_RDATA) begin
      ctl.stepPtr = 1'b1;
      if (txMasterAck) ctl.issueRd = 1'b1;
      else stateD = ST_SKIP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      ackValid <= 1'b0;
      ackBit   <= 1'b0;
      swReset  <= 1'b0;
    end else begin
      stateQ   <= stateD;
      ackValid <= ackVD;
      ackBit   <= ackBD;
      swReset  <= rstD;
    end
  end

  assign txActive = (stateQ == ST_RDATA);

  // R2: an ack decision only follows a received byte
  assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(rxValid));

  // R4: reset call with read bit is refused
  assert_reset_read_nack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR && rxValid && !busStart && !busStop && rxByte == {RESET_ADDR, 1'b1})
    |=> (ackValid && !ackBit));

  // R9: controller NACK closes the read
  assert_read_ends_on_nack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RDATA && txDone && !txMasterAck && !busStart && !busStop && !rxValid)
    |=> !txActive);

  // R10: a reset pulse needs a STOP after the complete sequence
  assert_reset_needs_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    swReset |-> $past(busStop && stateQ == ST_RSTOK));
endmodule

// File: rtl/aptr_datapath.sv
module aptr_datapath #(
  parameter int NUM_REGS = 28,
  parameter int PTR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  aptr_pkg::strobe_t ctl,
  input  logic [7:0]        rxByte,
  output logic [PTR_W-1:0]  regAddr,
  output logic [7:0]        wrData,
  output logic              wrStrobe,
  output logic              rdStrobe,
  output logic [2:0]        aiField
);
  import aptr_pkg::*;

  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptrQ, ptrStep;
  logic [2:0]       aiQ;

  always_comb begin
    ptrStep = ptrQ;
    if (aiQ != 3'd0) ptrStep = (ptrQ == LAST_REG) ? '0 : ptrQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ     <= '0;
      aiQ      <= '0;
      regAddr  <= '0;
      wrData   <= '0;
      wrStrobe <= 1'b0;
      rdStrobe <= 1'b0;
    end else begin
      wrStrobe <= ctl.issueWr;
      rdStrobe <= ctl.issueRd;
      if (ctl.issueWr) begin
        regAddr <= ptrQ;
        wrData  <= rxByte;
      end else if (ctl.issueRd) begin
        regAddr <= ctl.stepPtr ? ptrStep : ptrQ;
      end
      if (ctl.clearAll) begin
        ptrQ <= '0;
        aiQ  <= '0;
      end else if (ctl.loadCtrl) begin
        ptrQ <= rxByte[PTR_W-1:0];
        aiQ  <= rxByte[7:CTRL_AI_LSB];
      end else if (ctl.stepPtr) begin
        ptrQ <= ptrStep;
      end
    end
  end

  assign aiField = aiQ;

  // R7: pointer never leaves the register range
  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    32'(ptrQ) < NUM_REGS);

  // R7: a zero auto-increment field freezes the pointer
  assert_ptr_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (aiQ == 3'd0 && !ctl.loadCtrl && !ctl.clearAll) |=> (ptrQ == $past(ptrQ)));
endmodule

// File: rtl/i2c_addr_decoder.sv
module i2c_addr_decoder #(
  parameter int NUM_REGS = 28,
  parameter int NUM_SUB = 3,
  parameter logic [6:0] RESET_ADDR = 7'h03,
  parameter int PTR_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busStart,
  input  logic                 busStop,
  input  logic                 rxValid,
  input  logic [7:0]           rxByte,
  input  logic                 txDone,
  input  logic                 txMasterAck,
  input  logic [6:0]           hwAddr,
  input  logic [6:0]           allCallAddr,
  input  logic                 allCallEn,
  input  logic [NUM_SUB*7-1:0] subAddr,
  input  logic [NUM_SUB-1:0]   subEn,
  output logic                 ackValid,
  output logic                 ackBit,
  output logic                 txActive,
  output logic                 wrStrobe,
  output logic                 rdStrobe,
  output logic [PTR_W-1:0]     regAddr,
  output logic [7:0]           wrData,
  output logic [2:0]           aiField,
  output logic                 swReset
);
  aptr_pkg::strobe_t ctl;
  logic hit, resetHit;

  aptr_match #(.NUM_SUB(NUM_SUB), .RESET_ADDR(RESET_ADDR)) i_match (
    .addr(rxByte[7:1]), .hwAddr(hwAddr), .allCallAddr(allCallAddr),
    .allCallEn(allCallEn), .subAddr(subAddr), .subEn(subEn),
    .hit(hit), .resetHit(resetHit)
  );

  aptr_control #(.NUM_REGS(NUM_REGS), .RESET_ADDR(RESET_ADDR)) i_control (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .txDone(txDone), .txMasterAck(txMasterAck),
    .hit(hit), .resetHit(resetHit), .ctl(ctl), .ackValid(ackValid),
    .ackBit(ackBit), .txActive(txActive), .swReset(swReset)
  );

  aptr_datapath #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte), .regAddr(regAddr),
    .wrData(wrData), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .aiField(aiField)
  );
endmodule

// File: tb/test_i2c_addr_decoder.sv
module test_i2c_addr_decoder;
  logic clk = 1'b0, rstN = 1'b0;
  logic busStart = 0, busStop = 0, rxValid = 0, txDone = 0, txMasterAck = 0;
  logic [7:0] rxByte = '0;
  logic [6:0] hwAddr = 7'h40, allCallAddr = 7'h70;
  logic allCallEn = 1'b0;
  logic [20:0] subAddr = {7'h74, 7'h72, 7'h71};
  logic [2:0] subEn = 3'b000;
  logic ackValid, ackBit, txActive, wrStrobe, rdStrobe, swReset;
  logic [4:0] regAddr;
  logic [7:0] wrData;
  logic [2:0] aiField;
  int testCount = 0, failCount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_addr_decoder i_i2c_addr_decoder (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busStop(busStop),
    .rxValid(rxValid), .rxByte(rxByte), .txDone(txDone), .txMasterAck(txMasterAck),
    .hwAddr(hwAddr), .allCallAddr(allCallAddr), .allCallEn(allCallEn),
    .subAddr(subAddr), .subEn(subEn), .ackValid(ackValid), .ackBit(ackBit),
    .txActive(txActive), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .regAddr(regAddr), .wrData(wrData), .aiField(aiField), .swReset(swReset)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); busStart = 1; @(negedge clk); busStart = 0;
  endtask

  task automatic pulseStop(input bit expRst, input string tag);
    @(negedge clk); busStop = 1; @(negedge clk); busStop = 0;
    check(swReset == expRst, tag, swReset, expRst);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string tag);
    @(negedge clk); rxByte = b; rxValid = 1; @(negedge clk); rxValid = 0;
    check(ackValid && ackBit == expAck, tag, {ackValid, ackBit}, {1'b1, expAck});
  endtask

  task automatic ctrlAck(input bit ack);
    @(negedge clk); txDone = 1; txMasterAck = ack; @(negedge clk); txDone = 0;
  endtask

  task automatic t_reset();
    check(!ackValid && !wrStrobe && !rdStrobe && !swReset && !txActive, "R1 outputs idle", 0, 0);
    check(aiField == 0, "R1 aiField", aiField, 0);
  endtask

  task automatic t_hwWrite();
    pulseStart();
    sendByte(8'h80, 1, "R2 hw write addr");
    check(!txActive, "R2 no tx on write", txActive, 0);
    sendByte(8'h84, 1, "R5 ctrl byte");
    check(aiField == 3'd4, "R5 aiField", aiField, 4);
    sendByte(8'h11, 1, "R6 data ack");
    check(wrStrobe && regAddr == 4 && wrData == 8'h11, "R6 write strobe", {wrStrobe, regAddr, wrData}, {1'b1, 5'd4, 8'h11});
    sendByte(8'h22, 1, "R7 data2 ack");
    check(wrStrobe && regAddr == 5, "R7 advance", regAddr, 5);
    pulseStop(0, "R11 stop no reset");
  endtask

  task automatic t_wrap();
    pulseStart();
    sendByte(8'h80, 1, "R2 addr");
    sendByte(8'hBB, 1, "R5 ctrl ptr 27");
    sendByte(8'h01, 1, "R6 data");
    check(wrStrobe && regAddr == 27, "R7 last reg", regAddr, 27);
    sendByte(8'h02, 1, "R6 data");
    check(wrStrobe && regAddr == 0, "R7 wrap to 0", regAddr, 0);
    pulseStop(0, "R11 stop");
  endtask

  task automatic t_fixed();
    pulseStart();
    sendByte(8'h80, 1, "R2 addr");
    sendByte(8'h03, 1, "R5 ctrl fixed");
    check(aiField == 0, "R5 aiField zero", aiField, 0);
    sendByte(8'h33, 1, "R6 data");
    check(wrStrobe && regAddr == 3, "R7 fixed 1", regAddr, 3);
    sendByte(8'h44, 1, "R6 data");
    check(wrStrobe && regAddr == 3 && wrData == 8'h44, "R7 fixed 2", regAddr, 3);
    pulseStop(0, "R11 stop");
  endtask

  task automatic t_badCtrl();
    pulseStart();
    sendByte(8'h80, 1, "R2 addr");
    sendByte(8'h9F, 0, "R5 out of range ctrl nack");
    check(aiField == 0, "R5 aiField unchanged", aiField, 0);
    sendByte(8'h55, 0, "R5 later byte nack");
    check(!wrStrobe, "R5 no write", wrStrobe, 0);
    pulseStop(0, "R11 stop");
    pulseStart();
    sendByte(8'h81, 1, "R8 read addr");
    check(txActive && rdStrobe && regAddr == 3, "R5 pointer kept", regAddr, 3);
    pulseStop(0, "R11 stop");
  endtask

  task automatic t_read();
    pulseStart();
    sendByte(8'h80, 1, "R2 addr");
    sendByte(8'h8A, 1, "R5 ctrl ptr 10");
    pulseStop(0, "R11 stop");
    pulseStart();
    sendByte(8'h81, 1, "R8 read addr");
    check(txActive && rdStrobe && regAddr == 10, "R8 first read", regAddr, 10);
    ctrlAck(1);
    check(rdStrobe && regAddr == 11, "R8 next read", regAddr, 11);
    ctrlAck(0);
    check(!rdStrobe && !txActive, "R9 nack ends read", {rdStrobe, txActive}, 0);
    sendByte(8'h12, 0, "R9 bytes nacked after end");
    pulseStop(0, "R11 stop");
    pulseStart();
    sendByte(8'h81, 1, "R8 read addr");
    check(rdStrobe && regAddr == 12, "R9 pointer advanced on nack", regAddr, 12);
    pulseStop(0, "R11 stop");
  endtask

  task automatic t_noMatch();
    pulseStart();
    sendByte(8'h82, 0, "R2 mismatch nack");
    sendByte(8'h00, 0, "R2 following nack");
    check(!wrStrobe, "R2 no write", wrStrobe, 0);
    pulseStop(0, "R11 stop");
  endtask

  task automatic t_sub();
    pulseStart(); sendByte(8'hE4, 0, "R3 sub disabled"); pulseStop(0, "R11 stop");
    subEn = 3'b010;
    pulseStart(); sendByte(8'hE4, 1, "R3 sub enabled"); pulseStop(0, "R11 stop");
    pulseStart(); sendByte(8'hE2, 0, "R3 other sub disabled"); pulseStop(0, "R11 stop");
    pulseStart(); sendByte(8'hE0, 0, "R3 allcall disabled"); pulseStop(0, "R11 stop");
    allCallEn = 1;
    pulseStart(); sendByte(8'hE0, 1, "R3 allcall enabled"); pulseStop(0, "R11 stop");
  endtask

  task automatic t_rstRead();
    pulseStart();
    sendByte(8'h07, 0, "R4 reset call read nack");
    pulseStop(0, "R4 no reset");
  endtask

  task automatic t_rstOk();
    pulseStart();
    sendByte(8'h06, 1, "R4 reset call write ack");
    sendByte(8'hA5, 1, "R10 first key");
    sendByte(8'h5A, 1, "R10 second key");
    pulseStop(1, "R10 reset pulse");
    check(aiField == 0, "R10 aiField cleared", aiField, 0);
    pulseStart();
    sendByte(8'h81, 1, "R8 read addr");
    check(rdStrobe && regAddr == 0, "R10 pointer cleared", regAddr, 0);
    pulseStop(0, "R11 stop");
  endtask

  task automatic t_rstBad();
    pulseStart(); sendByte(8'h06, 1, "R4 addr"); sendByte(8'hA5, 1, "R10 key1");
    sendByte(8'h5B, 0, "R10 wrong key2"); pulseStop(0, "R10 no reset wrong key");
    pulseStart(); sendByte(8'h06, 1, "R4 addr"); sendByte(8'hA5, 1, "R10 key1");
    pulseStop(0, "R10 no reset short");
    pulseStart(); sendByte(8'h06, 1, "R4 addr"); sendByte(8'hA5, 1, "R10 key1");
    sendByte(8'h5A, 1, "R10 key2"); sendByte(8'h00, 0, "R10 extra byte nack");
    pulseStop(0, "R10 no reset extra");
    pulseStart(); sendByte(8'h06, 1, "R4 addr"); sendByte(8'hA5, 1, "R10 key1");
    sendByte(8'h5A, 1, "R10 key2"); pulseStart();
    check(!swReset, "R11 restart no reset", swReset, 0);
    pulseStop(0, "R11 stop after restart");
  endtask

  task automatic t_restart();
    pulseStart();
    sendByte(8'h80, 1, "R2 addr");
    sendByte(8'h86, 1, "R5 ctrl ptr 6");
    pulseStart();
    sendByte(8'h81, 1, "R11 repeated start read");
    check(txActive && rdStrobe && regAddr == 6, "R11 read after restart", regAddr, 6);
    pulseStop(0, "R11 stop");
    check(!txActive, "R11 idle after stop", txActive, 0);
    sendByte(8'h80, 0, "R11 byte without start nack");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_hwWrite();
    t_wrap();
    t_fixed();
    t_badCtrl();
    t_read();
    t_noMatch();
    t_sub();
    t_rstRead();
    t_rstOk();
    t_rstBad();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule